// File: doc/BRIEF.md
# Parallel I/O Port Pair with Handshake Strobe

This block provides two 8-bit bidirectional parallel ports, A and B, behind a small register bus. Each port has an output data latch and a direction register. The block drives a per-pin output enable and output value, and it samples the live pin levels. A read of either data address returns the levels on the pins, not the latch contents, so input bits and output bits both show the real state of the wire.

Every access to the port B data address is followed by a one-cycle active-low handshake strobe. A peer device can use this strobe as "data ready" after a write, or as "data accepted" after a read. For a 16-bit transfer, port A is accessed first and port B last, so the strobe marks the end of the pair.

A separate edge input is synchronised inside the block. Each falling edge on it latches an interrupt flag, and the flag drives an active-low interrupt output when that output is enabled. Two override inputs can take over the top two port B pins, for use by an external timer.

Top module: `pio_hs_port`

## Requirements
- R1: A write (`cs`=1, `rnw`=0) takes effect at the clock edge. The address selects the register: 0 is the port A latch, 1 the port B latch, 2 the port A direction and 3 the port B direction. `pa_out` and `pb_out` show the latches.
- R2: A direction bit of 1 makes the matching pin an output (`pa_oe`/`pb_oe` bit = 1). A direction bit of 0 makes it an input.
- R3: A read (`cs`=1, `rnw`=1) returns data combinationally. Address 0 returns `pa_in`, address 1 returns `pb_in`, and addresses 2 and 3 return the direction registers. When no read is in progress, `rdata` is 0.
- R4: After each read or write of address 1, `hs_n` is low for exactly the one clock cycle that follows the access edge.
- R5: Accesses to addresses 0, 2 and 3 leave `hs_n` high.
- R6: A falling edge on `edge_in` sets the interrupt flag. With `irq_en`=1, `irq_n` goes low after the third rising clock edge that follows the fall. A rising edge sets nothing.
- R7: The flag stays set until a cycle with `irq_clr`=1. If a new edge is detected in that same cycle, the set wins.
- R8: With `irq_en`=0, `irq_n` stays high but the flag is kept. Raising `irq_en` then drives `irq_n` low at once.
- R9: When `ovr_en[1]` or `ovr_en[0]` is 1, port B bit 7 or bit 6 respectively becomes an output carrying `ovr_val[1]` or `ovr_val[0]`, whatever the direction and latch bits hold.
- R10: After reset, all four registers are 0, every pin is an input, `hs_n`=1 and `irq_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access select |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Sampled port A pin levels |
| pa_oe | output | 8 | Port A output enables |
| pa_out | output | 8 | Port A output values |
| pb_in | input | 8 | Sampled port B pin levels |
| pb_oe | output | 8 | Port B output enables |
| pb_out | output | 8 | Port B output values |
| ovr_en | input | 2 | Override enables for port B bits 7 and 6 |
| ovr_val | input | 2 | Override values for port B bits 7 and 6 |
| hs_n | output | 1 | Active-low handshake strobe |
| edge_in | input | 1 | Asynchronous falling-edge event input |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `edge_in` is high when reset is released. A low level at that point would be seen as a falling edge. They also assume that `irq_clr` is never held across the cycle in which a detected edge is pending. The stimulus raises `edge_in` before reset ends and gives `irq_clr` only as a single-cycle pulse long after each edge has settled. All bus inputs change on the falling clock edge, so every access is one clean cycle.

// File: rtl/pio_hs_port.sv
module pio_hs_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rnw,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_oe,
  output logic [W-1:0] pa_out,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_oe,
  output logic [W-1:0] pb_out,
  input  logic [1:0]   ovr_en,
  input  logic [1:0]   ovr_val,
  output logic         hs_n,
  input  logic         edge_in,
  input  logic         irq_en,
  input  logic         irq_clr,
  output logic         irq_n
);
  localparam logic [1:0] AD_A   = 2'd0;
  localparam logic [1:0] AD_B   = 2'd1;
  localparam logic [1:0] AD_DA  = 2'd2;
  localparam logic [1:0] AD_DB  = 2'd3;
  localparam int         LOW_W  = W - 2;

  logic [W-1:0] lat_a, lat_b, dir_a, dir_b;
  logic         wr_en, b_acc;
  logic         sy1, sy2, sy_prev, ev_fall, flag;

  assign wr_en = cs && !rnw;
  assign b_acc = cs && (addr == AD_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      dir_a <= '0;
      dir_b <= '0;
    end else if (wr_en) begin
      case (addr)
        AD_A:    lat_a <= wdata;
        AD_B:    lat_b <= wdata;
        AD_DA:   dir_a <= wdata;
        default: dir_b <= wdata;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && rnw) begin
      case (addr)
        AD_A:    rdata = pa_in;
        AD_B:    rdata = pb_in;
        AD_DA:   rdata = dir_a;
        default: rdata = dir_b;
      endcase
    end
  end

  assign pa_oe  = dir_a;
  assign pa_out = lat_a;
  assign pb_oe  = {dir_b[W-1] | ovr_en[1], dir_b[W-2] | ovr_en[0], dir_b[LOW_W-1:0]};
  assign pb_out = {ovr_en[1] ? ovr_val[1] : lat_b[W-1],
                   ovr_en[0] ? ovr_val[0] : lat_b[W-2],
                   lat_b[LOW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_n <= 1'b1;
    else        hs_n <= !b_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1     <= 1'b1;
      sy2     <= 1'b1;
      sy_prev <= 1'b1;
    end else begin
      sy1     <= edge_in;
      sy2     <= sy1;
      sy_prev <= sy2;
    end
  end

  assign ev_fall = sy_prev && !sy2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (ev_fall) flag <= 1'b1;
    else if (irq_clr) flag <= 1'b0;
  end

  assign irq_n = !(flag && irq_en);

  AST_HS_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_acc |=> !hs_n) else $error("hs_n not low after port B access"); // R4
  AST_HS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !b_acc |=> hs_n) else $error("hs_n low without port B access"); // R5
  AST_DIR_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AD_DA) |=> (pa_oe == $past(wdata))) else $error("direction write lost"); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !irq_clr) |=> flag) else $error("flag dropped without clear"); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> flag) else $error("edge did not set flag"); // R6
endmodule

// File: tb/tb_pio_hs_port.sv
module tb_pio_hs_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr[27:26], rnw[25], wdata[24:17], pin[16:9], exp_rd[8:1], exp_hs[0]}
  localparam logic [27:0] VEC [NV] = '{
    {2'd2, 1'b0, 8'hF0, 8'h00, 8'h00, 1'b1},
    {2'd2, 1'b1, 8'h00, 8'h00, 8'hF0, 1'b1},
    {2'd0, 1'b0, 8'hA5, 8'h00, 8'h00, 1'b1},
    {2'd0, 1'b1, 8'h00, 8'h3C, 8'h3C, 1'b1},
    {2'd1, 1'b0, 8'h5A, 8'h00, 8'h00, 1'b0},
    {2'd1, 1'b1, 8'h00, 8'h3C, 8'hC3, 1'b0},
    {2'd3, 1'b0, 8'h0F, 8'h00, 8'h00, 1'b1},
    {2'd3, 1'b1, 8'h00, 8'h00, 8'h0F, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, rnw = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [7:0] rdata, pa_oe, pa_out, pb_oe, pb_out;
  logic [1:0] ovr_en = '0, ovr_val = '0;
  logic hs_n, irq_n;
  logic edge_in = 1'b1, irq_en = 1'b0, irq_clr = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_hs_port dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rnw(rnw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_oe(pa_oe), .pa_out(pa_out),
    .pb_in(pb_in), .pb_oe(pb_oe), .pb_out(pb_out), .ovr_en(ovr_en),
    .ovr_val(ovr_val), .hs_n(hs_n), .edge_in(edge_in), .irq_en(irq_en),
    .irq_clr(irq_clr), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles(2);
    chk("R10 pa_oe", pa_oe, 8'h00);
    chk("R10 pb_oe", pb_oe, 8'h00);
    chk("R10 pa_out", pa_out, 8'h00);
    chk("R10 hs_n", {7'd0, hs_n}, 8'h01);
    chk("R10 irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    cycles(2);

    // R1 R3 R4 R5: table walk
    for (int v = 0; v < NV; v++) begin
      cs = 1'b1;
      addr = VEC[v][27:26];
      rnw = VEC[v][25];
      wdata = VEC[v][24:17];
      pa_in = VEC[v][16:9];
      pb_in = ~VEC[v][16:9];
      #1;
      if (VEC[v][25]) chk("R3 read data", rdata, VEC[v][8:1]);
      @(negedge clk);
      cs = 1'b0;
      rnw = 1'b1;
      chk(VEC[v][0] ? "R5 no strobe" : "R4 strobe", {7'd0, hs_n}, {7'd0, VEC[v][0]});
      #1;
      chk("R3 idle rdata", rdata, 8'h00);
    end

    chk("R1 pa_out latch", pa_out, 8'hA5);
    chk("R1 pb_out latch", pb_out, 8'h5A);
    chk("R2 pa_oe", pa_oe, 8'hF0);
    chk("R2 pb_oe", pb_oe, 8'h0F);

    // R4 exactly one cycle
    cs = 1'b1; rnw = 1'b1; addr = 2'd1;
    @(negedge clk); cs = 1'b0;
    chk("R4 low after access", {7'd0, hs_n}, 8'h00);
    @(negedge clk);
    chk("R4 high one cycle later", {7'd0, hs_n}, 8'h01);

    // R9 overrides
    ovr_en = 2'b11; ovr_val = 2'b10; #1;
    chk("R9 override oe", pb_oe, 8'hCF);
    chk("R9 override out", pb_out, 8'h9A);
    ovr_en = 2'b01; ovr_val = 2'b00; #1;
    chk("R9 bit6 only oe", pb_oe, 8'h4F);
    chk("R9 bit6 only out", pb_out, 8'h1A);
    ovr_en = 2'b00; #1;
    chk("R9 release", pb_out, 8'h5A);

    // R6 edge latency
    irq_en = 1'b1;
    edge_in = 1'b0;
    cycles(2);
    chk("R6 not yet", {7'd0, irq_n}, 8'h01);
    cycles(1);
    chk("R6 irq low", {7'd0, irq_n}, 8'h00);
    edge_in = 1'b1;
    cycles(6);
    chk("R7 held, rise ignored", {7'd0, irq_n}, 8'h00);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    chk("R7 cleared", {7'd0, irq_n}, 8'h01);
    cycles(5);
    chk("R6 rising edge sets nothing", {7'd0, irq_n}, 8'h01);

    // R8 masking
    irq_en = 1'b0;
    edge_in = 1'b0;
    cycles(5);
    chk("R8 masked", {7'd0, irq_n}, 8'h01);
    irq_en = 1'b1; #1;
    chk("R8 flag kept", {7'd0, irq_n}, 8'h00);
    edge_in = 1'b1;
    cycles(3);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    chk("R7 clear again", {7'd0, irq_n}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule